// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

A single-clock static memory with a 64-bit word that registers its address, write data, chip enables and write controls on the rising clock edge. Either of two address strobes starts an access at an external address. After that, a 2-bit internal counter steps through the other three words of the aligned four-word group each time the advance input is low. The burst order is linear or interleaved, and the asynchronous order-select input chooses between them.

The byte-write controls work in layers. Per-byte enables take effect only while the byte-write gate is low. The global write input overrides both and writes the whole word. A read returns its word one clock after the address is presented. That word passes to the output through an asynchronous output enable, and the output is all zeros while the enable is high. Five chip-enable inputs are sampled when an address is loaded, and they decide whether the whole burst is selected.

Top module: `burst_sram`

## Requirements
- R1: After reset, with the output enabled, rdata_o is all zeros. Advance cycles before any address load cause no access.
- R2: A read access at a clock edge places the addressed word on rdata_o after that edge. The word holds until the next read access.
- R3: Processor strobe low with ce_n_i high (and controller strobe high) is ignored: the loaded burst address and counter stay as they were, and an advance in that cycle proceeds normally. Controller strobe low always loads, and when both strobes are low the address is loaded once.
- R4: A load is selected only when ce_n_i, ce2_n_i and ce3_n_i are low and ce2_i and ce3_i are high. A deselected load, and every advance that follows it, performs no write and does not change rdata_o.
- R5: With mode_i low, burst addresses replace the two low address bits with (base + k) mod 4, for k = 1, 2, 3, 0, and so on.
- R6: With mode_i high, burst addresses replace the two low address bits with base XOR k.
- R7: With gw_n_i high and bwe_n_i low, bit n of bw_n_i low writes data bits [8n+7:8n], and bytes whose bit is high are kept.
- R8: With gw_n_i and bwe_n_i both high, bw_n_i has no effect and the access is a read.
- R9: gw_n_i low writes all eight bytes, whatever bwe_n_i and bw_n_i are.
- R10: oe_n_i high forces rdata_o to all zeros combinationally. It does not change the stored read word.
- R11: A cycle with both strobes and adv_n_i high holds the burst position and rdata_o.
- R12: A write access leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | DATA_W | Write data |
| ce_n_i | input | 1 | Primary chip enable, active low; also qualifies the processor strobe |
| ce2_n_i | input | 1 | Expansion enable, active low |
| ce3_n_i | input | 1 | Expansion enable, active low |
| ce2_i | input | 1 | Expansion enable, active high |
| ce3_i | input | 1 | Expansion enable, active high |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| bw_n_i | input | DATA_W/8 | Per-byte write enables, active low |
| bwe_n_i | input | 1 | Byte-write gate, active low |
| gw_n_i | input | 1 | Global write, active low |
| oe_n_i | input | 1 | Output enable, asynchronous, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | DATA_W | Read data |

## Verification
Two things can fall in the same clock: an address strobe and an advance, and a write-control decode and a burst step. The bench provokes both. It asserts the processor strobe during a running burst while the chip is disabled, so the advance must win. It also changes the byte masks on every beat of a write burst, so each byte lane must land at the address the counter produced in that cycle. A behavioural shadow memory with its own burst counter predicts rdata_o after every edge. It covers linear and interleaved bursts, all five chip enables and a long stretch of mixed random traffic, so a wrong address, a wrong byte lane or a missed hold all show up as a mismatch at the port.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic {BURST_LINEAR = 1'b0, BURST_XOR = 1'b1} burst_order_e;

  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input burst_order_e ord);
    return (ord == BURST_XOR) ? (base ^ step) : (base + step);
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              ce2_n_i,
  input  logic              ce3_n_i,
  input  logic              ce2_i,
  input  logic              ce3_i,
  input  logic              adsp_n_i,
  input  logic              adsc_n_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  output logic              acc_o,
  output logic [ADDR_W-1:0] acc_addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nxt;
  logic              sel_q, sel_now, load, step;
  burst_order_e      ord;

  assign ord     = burst_order_e'(mode_i);
  assign load    = (!adsp_n_i && !ce_n_i) || !adsc_n_i;  // processor strobe needs ce_n low
  assign sel_now = !ce_n_i && !ce2_n_i && !ce3_n_i && ce2_i && ce3_i;
  assign step    = !load && !adv_n_i && sel_q;
  assign cnt_nxt = cnt_q + 2'd1;

  assign acc_o      = load ? sel_now : step;
  assign acc_addr_o = load ? addr_i
                           : {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nxt, ord)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else if (load) begin
      base_q <= addr_i;
      cnt_q  <= '0;
      sel_q  <= sel_now;
    end else if (step) begin
      cnt_q  <= cnt_nxt;
    end
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsp_n_i && adsc_n_i && adv_n_i) |=> ($stable(cnt_q) && $stable(base_q)));

  // R3
  adsp_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_n_i && ce_n_i && adsc_n_i) |=> $stable(base_q));
endmodule

// File: rtl/byte_wr_dec.sv
module byte_wr_dec #(
  parameter int NBYTE = 8
) (
  input  logic             rst_ni,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [NBYTE-1:0] bw_n_i,
  output logic [NBYTE-1:0] mask_o
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign mask_o[b] = !gw_n_i || (!bwe_n_i && !bw_n_i[b]);
  end

  always_comb begin
    if (rst_ni && gw_n_i === 1'b0) begin
      // R9
      gw_all_chk: assert (&mask_o);
    end
    if (rst_ni && gw_n_i === 1'b1 && bwe_n_i === 1'b1) begin
      // R8
      bwe_off_chk: assert (mask_o == '0);
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int NBYTE  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NBYTE-1:0]   mask_i,
  input  logic [8*NBYTE-1:0] wdata_i,
  output logic [8*NBYTE-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [8*NBYTE-1:0] rd_word, rdata_q;
  logic               is_wr;

  assign is_wr = |mask_i;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (acc_i && mask_i[b]) lane_mem[addr_i] <= wdata_i[8*b +: 8];
    end
    assign rd_word[8*b +: 8] = lane_mem[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (acc_i && !is_wr)  rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;

  // R12
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && is_wr) |=> $stable(rdata_q));
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                ce_n_i,
  input  logic                ce2_n_i,
  input  logic                ce3_n_i,
  input  logic                ce2_i,
  input  logic                ce3_i,
  input  logic                adsp_n_i,
  input  logic                adsc_n_i,
  input  logic                adv_n_i,
  input  logic [DATA_W/8-1:0] bw_n_i,
  input  logic                bwe_n_i,
  input  logic                gw_n_i,
  input  logic                oe_n_i,
  input  logic                mode_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int NBYTE = DATA_W / 8;

  logic              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic [NBYTE-1:0]  mask;
  logic [DATA_W-1:0] word_q;

  burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .ce_n_i, .ce2_n_i, .ce3_n_i, .ce2_i, .ce3_i,
    .adsp_n_i, .adsc_n_i, .adv_n_i, .mode_i,
    .acc_o(acc), .acc_addr_o(acc_addr)
  );

  byte_wr_dec #(.NBYTE(NBYTE)) u_wdec (
    .rst_ni, .gw_n_i, .bwe_n_i, .bw_n_i, .mask_o(mask)
  );

  sram_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_array (
    .clk_i, .rst_ni, .acc_i(acc), .addr_i(acc_addr), .mask_i(mask),
    .wdata_i, .rdata_o(word_q)
  );

  assign rdata_o = oe_n_i ? '0 : word_q;

  always_comb begin
    if (oe_n_i === 1'b1) begin
      // R10
      oe_off_chk: assert (rdata_o == '0);
    end
  end
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ce_n = 0, ce2_n = 0, ce3_n = 0, ce2 = 1, ce3 = 1;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, bwe_n = 1, gw_n = 1, oe_n = 0, mode = 0;
  logic [7:0] bw_n = 8'hFF;
  logic [DW-1:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] mem_m [DEPTH];
  int m_base = 0, m_cnt = 0;
  bit m_sel = 0;
  logic [DW-1:0] m_rd = '0;

  always #4 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .ce_n_i(ce_n), .ce2_n_i(ce2_n), .ce3_n_i(ce3_n), .ce2_i(ce2), .ce3_i(ce3),
    .adsp_n_i(adsp_n), .adsc_n_i(adsc_n), .adv_n_i(adv_n), .bw_n_i(bw_n),
    .bwe_n_i(bwe_n), .gw_n_i(gw_n), .oe_n_i(oe_n), .mode_i(mode), .rdata_o(rdata)
  );

  // behavioural reference, evaluated once per rising edge on the inputs held there
  task automatic model_step();
    bit ld, acc;
    int a;
    logic [7:0] msk;
    ld  = (!adsp_n && !ce_n) || !adsc_n;
    acc = 0;
    a   = 0;
    if (ld) begin
      m_sel  = !ce_n && !ce2_n && !ce3_n && ce2 && ce3;
      m_base = int'(addr);
      m_cnt  = 0;
      acc    = m_sel;
      a      = m_base;
    end else if (!adv_n && m_sel) begin
      m_cnt = (m_cnt + 1) % 4;
      if (mode) a = (m_base & ~3) | ((m_base ^ m_cnt) & 3);
      else      a = (m_base & ~3) | ((m_base + m_cnt) & 3);
      acc = 1;
    end
    if (acc) begin
      for (int b = 0; b < 8; b++)
        msk[b] = !gw_n || (!bwe_n && !bw_n[b]);
      if (msk != 0) begin
        for (int b = 0; b < 8; b++)
          if (msk[b]) mem_m[a][8*b +: 8] = wdata[8*b +: 8];
      end else begin
        m_rd = mem_m[a];
      end
    end
  endtask

  task automatic check(input string tag);
    logic [DW-1:0] exp;
    exp = oe_n ? '0 : m_rd;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic p, input logic c, input logic v,
                     input logic g, input logic be, input logic [7:0] bw,
                     input logic [DW-1:0] d, input string tag);
    addr = a; adsp_n = p; adsc_n = c; adv_n = v; gw_n = g; bwe_n = be; bw_n = bw; wdata = d;
    @(posedge clk);
    model_step();
    #1 check(tag);
    @(negedge clk);
  endtask

  task automatic rd_load(input logic [AW-1:0] a, input string tag);
    cyc(a, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, '0, tag);
  endtask
  task automatic rd_adv(input string tag);
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, '0, tag);
  endtask
  task automatic idle(input string tag);
    cyc('0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, '0, tag);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return {32'(i * 32'h9E37_79B9), 32'(~i)};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1");
    rst_n = 1;
    @(negedge clk);
    // R1: advances before any load do nothing
    rd_adv("R1");
    rd_adv("R1");

    // fill via global write, controller strobe (R9)
    for (int i = 0; i < DEPTH; i++)
      cyc(AW'(i), 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, pat(i), "R9");

    // R2/R5: linear burst from base 5 via processor strobe
    mode = 0;
    cyc(8'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, '0, "R2");
    for (int k = 0; k < 5; k++) rd_adv("R5");

    // R6: interleaved burst from base 6
    mode = 1;
    rd_load(8'd6, "R6");
    for (int k = 0; k < 4; k++) rd_adv("R6");
    mode = 0;

    // R7: byte-write burst with a different mask each beat
    cyc(8'd9, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 64'h1111_2222_3333_4444, "R7");
    cyc(8'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0F, 64'h5555_6666_7777_8888, "R7");
    cyc(8'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFE, 64'h9999_AAAA_BBBB_CCCC, "R7");
    cyc(8'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h7F, 64'hDDDD_EEEE_FFFF_0000, "R7");
    rd_load(8'd9, "R7");
    for (int k = 0; k < 3; k++) rd_adv("R7");

    // R8: per-byte enables without the gate
    cyc(8'd20, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 64'hDEAD_BEEF_DEAD_BEEF, "R8");
    rd_load(8'd20, "R8");
    // R12: write right after a read keeps the output
    cyc(8'd21, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 64'h0123_4567_89AB_CDEF, "R12");
    // R9: global write overrides gate and enables
    cyc(8'd22, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 64'hCAFE_F00D_CAFE_F00D, "R9");
    rd_load(8'd21, "R12");
    rd_load(8'd22, "R9");

    // R3: ignored processor strobe during a burst; advance proceeds
    rd_load(8'd40, "R3");
    ce_n = 1;
    cyc(8'd99, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, '0, "R3");
    ce_n = 0;
    rd_adv("R3");
    cyc(8'd77, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, '0, "R3");
    rd_adv("R3");

    // R11: idle holds position and output
    idle("R11");
    idle("R11");
    rd_adv("R11");

    // R4: each enable deselects; writes and advances blocked
    for (int e = 0; e < 5; e++) begin
      ce_n = (e == 0); ce2_n = (e == 1); ce3_n = (e == 2); ce2 = (e != 3); ce3 = (e != 4);
      cyc(8'd30, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 64'hBAD0_BAD0_BAD0_BAD0, "R4");
      ce_n = 0; ce2_n = 0; ce3_n = 0; ce2 = 1; ce3 = 1;
      cyc(8'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 64'hBAD1_BAD1_BAD1_BAD1, "R4");
      rd_load(8'd30, "R4");
      rd_load(8'd31, "R4");
    end

    // R10: output enable is asynchronous
    oe_n = 1;
    #1 check("R10");
    idle("R10");
    oe_n = 0;
    #1 check("R10");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      ce_n  = ($urandom_range(0, 9) == 0);
      ce2   = ($urandom_range(0, 19) != 0);
      oe_n  = ($urandom_range(0, 7) == 0);
      mode  = $urandom_range(0, 1);
      cyc(AW'($urandom), $urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
          $urandom_range(0, 4) < 2, $urandom_range(0, 4) != 0, $urandom_range(0, 2) == 0,
          8'($urandom), {$urandom, $urandom}, "R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule